// File: doc/BRIEF.md
# Sleep-Capable 16-Bit Event Timer

This block is a 16-bit up-counter for a small microcontroller. A byte-wide register bus reaches it. Software picks what it counts: either the core's instruction-cycle strobe or rising edges on an external clock pin. An external edge can go through a multi-stage synchronizer or through a short, unsynchronized path. Only the unsynchronized path keeps counting while the core sleeps. Every synchronized mode halts during sleep. Counting can also be qualified by one of two gate pins, with selectable polarity. A power-of-two prescaler (1, 2, 4 or 8) sits between the selected source and the counter.

When the count wraps from 0xFFFF to 0x0000 the block sets an overflow flag. The flag is combined with a local enable and an external peripheral-interrupt enable to form a wake request. The wake request is further combined with the global interrupt enable to form a vector request. When global interrupts are off, the core wakes and carries on at its next instruction instead of taking the vector. A control bit for the shared low-power oscillator forces the two pins it borrows to read as 0, and their direction bits to read as 1.

All registers live in one clock domain, which is sampled by a free-running clock. Bus reads therefore always return a coherent byte. The bus is a plain single-cycle register port: writes take effect at the clock edge and reads are combinational. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr16_wake`

## Requirements
- R1: After reset, the control register (address 2), the flag register (address 3), the enable register (address 4) and the gate-select register (address 5) all read 0x00, and wake_req is 0.
- R2: Address 0 holds the low count byte and address 1 the high count byte. While run (control bit 0) is 0, a written value reads back unchanged and the count does not move.
- R3: With control bit 1 = 0, the counter counts icyc_tick pulses through the prescaler. Control bits 5:4 = 0,1,2,3 select divide-by 1,2,4,8. Writing either count byte clears the prescaler, so n pulses after such a write add floor(n / 2^sel).
- R4: With control bit 1 = 1, the counter counts rising edges of ext_clk and ignores icyc_tick. Control bit 2 = 1 selects the unsynchronized edge path and 0 selects the synchronizer.
- R5: While sleep is 1, the count advances only in unsynchronized external mode (control bits 2:1 = 11). It holds in every other mode.
- R6: A count step from 0xFFFF to 0x0000 sets ovf_flag, which reads at bit 0 of address 3. Writing 0 to that bit clears the flag.
- R7: wake_req = ovf_flag AND enable bit 0 of address 4 AND periph_ie. vector_req = wake_req AND global_ie, so a wake with global_ie = 0 asks for no vector.
- R8: With control bit 6 = 1, counting happens only while (selected gate pin XOR control bit 7) is 1. Address 5 bit 0 selects the pin: 0 = gate_a, 1 = gate_b. With control bit 6 = 0, the gate pins have no effect.
- R9: With control bit 3 = 1, pin_rd reads 2'b00 and dir_rd reads 2'b11. With the bit at 0, they pass pin_in and dir_in through.
- R10: A count-byte write while run = 1 is held until the next count event. On that event the written byte(s) load and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low power-on/brown-out reset (count bytes are not reset) |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| icyc_tick | input | 1 | One-cycle instruction-clock strobe |
| sleep | input | 1 | Core is asleep |
| ext_clk | input | 1 | External count clock |
| gate_a | input | 1 | Gate source 0 |
| gate_b | input | 1 | Gate source 1 |
| periph_ie | input | 1 | Peripheral-interrupt enable from the core |
| global_ie | input | 1 | Global interrupt enable from the core |
| pin_in | input | 2 | Raw levels of the two oscillator-shared pins |
| dir_in | input | 2 | Direction bits of the shared pins |
| pin_rd | output | 2 | Pin levels as software reads them |
| dir_rd | output | 2 | Direction bits as software reads them |
| ovf_flag | output | 1 | Overflow flag |
| wake_req | output | 1 | Wake request |
| vector_req | output | 1 | Request to vector to the interrupt handler |

## Verification
The hardest case is a wake caused by an overflow while the core sleeps with global interrupts off. It needs the unsynchronized external mode, a count preloaded to 0xFFFF while stopped, both enables set, and then one external edge delivered during sleep. The bench builds that sequence directly and checks that wake_req rises while vector_req stays low. Beyond that case, the bench sweeps every prescale ratio against a range of pulse counts, every combination of gate enable, polarity, source and level, and every combination of the three enables.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_CTRL   = 3'd2,
    A_FLAG   = 3'd3,
    A_IEN    = 3'd4,
    A_GSEL   = 3'd5
  } reg_addr_e;

  // bit 7 down to bit 0
  typedef struct packed {
    logic       gate_inv;
    logic       gate_en;
    logic [1:0] psel;
    logic       osc_en;
    logic       nosync;
    logic       ext_src;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic nosync,
  output logic edge_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;
  logic [1:0]      fast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      fast <= '0;
    end else begin
      sh   <= {sh[SH_W-2:0], ext_in};
      fast <= {fast[0], ext_in};
    end
  end

  logic sync_edge, fast_edge;
  assign sync_edge = sh[SH_W-2] & ~sh[SH_W-1];
  assign fast_edge = fast[0] & ~fast[1];
  assign edge_o    = nosync ? fast_edge : sync_edge;
endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            src,
  input  logic [PS_W-1:0] psel,
  output logic            tick_o
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] p;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(psel));
  end

  assign tick_o = src & ((p & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   p <= '0;
    else if (clr) p <= '0;
    else if (src) p <= p + 1'b1;
  end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              inc,
  input  logic [NB-1:0]     wr_sel,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [CNT_W-1:0]  count,
  output logic              ovf,
  output logic              pend_any
);
  logic [NB-1:0]             pv;
  logic [NB-1:0][BYTE_W-1:0] pval;
  logic                      apply;

  assign pend_any = |pv;
  assign apply    = pend_any & (inc | ~run);

  for (genvar b = 0; b < NB; b++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pv[b]   <= 1'b0;
        pval[b] <= '0;
      end else if (wr_sel[b]) begin
        pv[b]   <= 1'b1;
        pval[b] <= wr_byte;
      end else if (apply) begin
        pv[b]   <= 1'b0;
      end
    end
  end

  logic [CNT_W-1:0] nxt;
  always_comb begin
    nxt = count;
    if (apply) begin
      for (int b = 0; b < NB; b++)
        if (pv[b]) nxt[b*BYTE_W +: BYTE_W] = pval[b];
    end else if (inc) begin
      nxt = count + 1'b1;
    end
  end

  // count bytes keep their value across resets
  always_ff @(posedge clk) count <= nxt;

  assign ovf = inc & ~apply & (&count);
endmodule

// File: rtl/tmr16_wake.sv
module tmr16_wake
  import tmr16_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BUS_W       = 8,
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              icyc_tick,
  input  logic              sleep,
  input  logic              ext_clk,
  input  logic              gate_a,
  input  logic              gate_b,
  input  logic              periph_ie,
  input  logic              global_ie,
  input  logic [1:0]        pin_in,
  input  logic [1:0]        dir_in,
  output logic [1:0]        pin_rd,
  output logic [1:0]        dir_rd,
  output logic              ovf_flag,
  output logic              wake_req,
  output logic              vector_req
);
  localparam int NB = CNT_W / BUS_W;

  ctrl_t ctrl;
  logic  ien, gsel;
  logic  run_on, osc_on, async_mode;

  assign run_on     = ctrl.run;
  assign osc_on     = ctrl.osc_en;
  assign async_mode = ctrl.ext_src & ctrl.nosync;

  reg_addr_e a;
  assign a = reg_addr_e'(bus_addr);

  // register bank
  logic ovf;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      ien      <= 1'b0;
      gsel     <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (bus_we && a == A_CTRL) ctrl <= ctrl_t'(bus_wdata);
      if (bus_we && a == A_IEN)  ien  <= bus_wdata[0];
      if (bus_we && a == A_GSEL) gsel <= bus_wdata[0];
      if (ovf)                        ovf_flag <= 1'b1;
      else if (bus_we && a == A_FLAG) ovf_flag <= bus_wdata[0];
    end
  end

  // count source selection and qualification
  logic ext_edge, src_edge, gate_lvl, gate_ok, awake_ok, src;

  tmr16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ext_in(ext_clk),
    .nosync(ctrl.nosync),
    .edge_o(ext_edge)
  );

  assign src_edge = ctrl.ext_src ? ext_edge : icyc_tick;
  assign gate_lvl = gsel ? gate_b : gate_a;
  assign gate_ok  = ~ctrl.gate_en | (gate_lvl ^ ctrl.gate_inv);
  assign awake_ok = ~sleep | async_mode;
  assign src      = run_on & awake_ok & gate_ok & src_edge;

  logic [NB-1:0] cnt_wr;
  logic          cnt_wr_any;
  for (genvar b = 0; b < NB; b++) begin : g_wsel
    assign cnt_wr[b] = bus_we && (bus_addr == ADDR_W'(int'(A_CNT_LO) + b));
  end
  assign cnt_wr_any = |cnt_wr;

  logic inc;
  tmr16_presc #(.PS_W(PS_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_wr_any),
    .src   (src),
    .psel  (ctrl.psel),
    .tick_o(inc)
  );

  logic [CNT_W-1:0] count;
  logic             pend_any;
  tmr16_count #(.CNT_W(CNT_W), .BYTE_W(BUS_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_on),
    .inc     (inc),
    .wr_sel  (cnt_wr),
    .wr_byte (bus_wdata),
    .count   (count),
    .ovf     (ovf),
    .pend_any(pend_any)
  );

  // outputs
  assign wake_req   = ovf_flag & ien & periph_ie;
  assign vector_req = wake_req & global_ie;
  assign pin_rd     = osc_on ? 2'b00 : pin_in;
  assign dir_rd     = osc_on ? 2'b11 : dir_in;

  always_comb begin
    bus_rdata = '0;
    case (a)
      A_CNT_LO: bus_rdata = count[BUS_W-1:0];
      A_CNT_HI: bus_rdata = count[2*BUS_W-1:BUS_W];
      A_CTRL:   bus_rdata = BUS_W'(ctrl);
      A_FLAG:   bus_rdata[0] = ovf_flag;
      A_IEN:    bus_rdata[0] = ien;
      A_GSEL:   bus_rdata[0] = gsel;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_wake_chk.sv
module tmr16_wake_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             sleep,
  input logic             async_mode,
  input logic             cnt_wr_any,
  input logic             pend_any,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic             ovf_flag,
  input logic             osc_en,
  input logic [1:0]       pin_rd,
  input logic [1:0]       dir_rd,
  input logic             wake_req,
  input logic             vector_req
);
  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr_any && !pend_any) |=> $stable(count));

  // R5
  sleep_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !async_mode && !cnt_wr_any && !pend_any) |=> $stable(count));

  // R6
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf_flag);

  // R9
  osc_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> (pin_rd == 2'b00 && dir_rd == 2'b11));

  // R7
  wake_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ovf_flag);

  // R7
  vector_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vector_req |-> wake_req);
endmodule

bind tmr16_wake tmr16_wake_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run_on),
  .sleep     (sleep),
  .async_mode(async_mode),
  .cnt_wr_any(cnt_wr_any),
  .pend_any  (pend_any),
  .count     (count),
  .ovf       (ovf),
  .ovf_flag  (ovf_flag),
  .osc_en    (osc_on),
  .pin_rd    (pin_rd),
  .dir_rd    (dir_rd),
  .wake_req  (wake_req),
  .vector_req(vector_req)
);

// File: tb/tmr16_wake_test.sv
module tmr16_wake_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       icyc_tick = 1'b0, sleep = 1'b0, ext_clk = 1'b0;
  logic       gate_a = 1'b0, gate_b = 1'b0;
  logic       periph_ie = 1'b0, global_ie = 1'b0;
  logic [1:0] pin_in = '0, dir_in = '0, pin_rd, dir_rd;
  logic       ovf_flag, wake_req, vector_req;

  int nvec = 0, nbad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr16_wake uut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(3'd0, lo); rd(3'd1, hi); c = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] c);
    wr(3'd0, c[7:0]); wr(3'd1, c[15:8]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); icyc_tick = 1'b1;
      @(negedge clk); icyc_tick = 1'b0;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (4) @(negedge clk); ext_clk = 1'b1;
      repeat (4) @(negedge clk); ext_clk = 1'b0;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int a = 2; a <= 5; a++) begin
      rd(3'(a), d); check("R1 reg after reset", d, 0);
    end
    check("R1 wake after reset", wake_req, 0);

    // R2 stopped read/write, no counting
    for (int k = 0; k < 8; k++) begin
      logic [15:0] v;
      v = 16'(k * 16'h2F3B) ^ 16'hA5C3;
      set_cnt(v); ticks(3);
      rd_cnt(c); check("R2 stopped readback", c, v);
    end

    // R3 prescaler sweep
    for (int ps = 0; ps < 4; ps++) begin
      for (int n = 0; n < 12; n++) begin
        set_cnt(16'h0000);
        wr(3'd2, 8'(ps << 4) | 8'h01);
        ticks(n);
        wr(3'd2, 8'h00);
        rd_cnt(c); check("R3 prescale count", c, n >> ps);
      end
    end

    // R4 external, synced and unsynced; ticks ignored
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 4; n++) begin
        set_cnt(16'h0100);
        wr(3'd2, m ? 8'h07 : 8'h03);
        pulses(n); ticks(3);
        wr(3'd2, 8'h00);
        rd_cnt(c); check("R4 external edge count", c, 16'h0100 + n);
      end
    end

    // R5 sleep behaviour per mode
    begin
      logic [7:0] modes [3] = '{8'h01, 8'h03, 8'h07};
      for (int m = 0; m < 3; m++) begin
        set_cnt(16'h0040);
        wr(3'd2, modes[m]);
        sleep = 1'b1;
        ticks(3); pulses(3);
        sleep = 1'b0;
        wr(3'd2, 8'h00);
        rd_cnt(c); check("R5 count in sleep", c, (m == 2) ? 16'h0043 : 16'h0040);
      end
    end

    // R6 overflow, R7 enable combinations
    set_cnt(16'hFFFE);
    wr(3'd2, 8'h01);
    ticks(1);
    rd(3'd3, d); check("R6 no flag at FFFF", d, 0);
    ticks(1);
    wr(3'd2, 8'h00);
    rd(3'd3, d); check("R6 flag after wrap", d, 1);
    rd_cnt(c); check("R6 count wraps", c, 0);
    for (int k = 0; k < 8; k++) begin
      wr(3'd4, 8'(k & 1));
      periph_ie = k[1]; global_ie = k[2];
      #1;
      check("R7 wake_req", wake_req, k[0] & k[1]);
      check("R7 vector_req", vector_req, k[0] & k[1] & k[2]);
    end
    wr(3'd3, 8'h00);
    rd(3'd3, d); check("R6 flag cleared", d, 0);
    check("R7 wake after clear", wake_req, 0);

    // R5/R7 wake from sleep with global interrupts off
    set_cnt(16'hFFFF);
    wr(3'd4, 8'h01); periph_ie = 1'b1; global_ie = 1'b0;
    wr(3'd2, 8'h07);
    sleep = 1'b1;
    check("R7 no wake before edge", wake_req, 0);
    pulses(1);
    check("R5 wake in sleep", wake_req, 1);
    check("R7 no vector when global off", vector_req, 0);
    sleep = 1'b0;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00); periph_ie = 1'b0;

    // R8 gate sweep
    for (int k = 0; k < 16; k++) begin
      logic ge, inv, sel, lvl;
      {ge, inv, sel, lvl} = 4'(k);
      wr(3'd5, {7'd0, sel});
      gate_a = sel ? ~lvl : lvl;
      gate_b = sel ? lvl : ~lvl;
      set_cnt(16'h0000);
      wr(3'd2, {inv, ge, 6'h01});
      ticks(4);
      wr(3'd2, 8'h00);
      rd_cnt(c); check("R8 gated count", c, (!ge || (lvl ^ inv)) ? 4 : 0);
    end
    wr(3'd5, 8'h00);

    // R9 oscillator pin override
    pin_in = 2'b11; dir_in = 2'b00;
    wr(3'd2, 8'h08); #1;
    check("R9 pins forced low", pin_rd, 2'b00);
    check("R9 dirs forced high", dir_rd, 2'b11);
    wr(3'd2, 8'h00); #1;
    check("R9 pins pass", pin_rd, 2'b11);
    check("R9 dirs pass", dir_rd, 2'b00);

    // R10 write while running
    set_cnt(16'h0005);
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h10); wr(3'd1, 8'h20);
    ticks(1);
    rd_cnt(c); check("R10 deferred load", c, 16'h2010);
    ticks(1);
    rd_cnt(c); check("R10 resumes counting", c, 16'h2011);
    wr(3'd2, 8'h00);

    finish_run();
  end
endmodule